// File: doc/BRIEF.md
# Half-Word Mode Bus Adapter

This block sits between a processor core that issues 32-bit word and 8-bit byte requests and a memory system with a 16-bit external data bus. For every request it looks up two attributes of the address segment: whether that segment runs in half-word mode, and whether it is cacheable. Cacheable requests from the core are passed whole to a cache port. Display refresh requests always take the external path, whatever the segment's cacheable bit says. All other requests are turned into one or two 16-bit transfers on the external bus.

With half-word mode off, a word takes two external transfers. The low half goes first at the word-aligned address, and the high half follows at that address plus 2. The read halves are joined before the core is told the access is done. With half-word mode on, a word becomes a single 16-bit transfer. On a read, the returned value is sign-extended to 32 bits. On a write, only the low half of the core's data is written. Bytes always take one transfer with a lane select.

The core holds a request until it sees a one-cycle ready pulse. The external bus and the cache port each use a request that is held until acknowledged.

Top module: `hw_bus_adapter`

## Requirements
- R1: After a synchronous active-low reset, core_ready, mem_req and cache_req are all low.
- R2: With half-word mode off, a word read makes two transfers: first at the address with bits [1:0] cleared, then at that address plus 2. core_rdata is {second half, first half}. core_ready pulses only after the second transfer is acknowledged.
- R3: With half-word mode off, a word write sends core_wdata[15:0] in the first transfer and core_wdata[31:16] in the second, both with mem_byte_en = 2'b11 and mem_write high.
- R4: With half-word mode on, a word read makes exactly one transfer at the address with bits [1:0] cleared. The 16-bit value is returned sign-extended to 32 bits.
- R5: With half-word mode on, a word write makes exactly one transfer carrying core_wdata[15:0] with mem_byte_en = 2'b11.
- R6: A byte write makes one transfer at the unmodified address, in either mode. core_wdata[7:0] is placed on both lanes. mem_byte_en is 2'b10 when address bit 0 is 1 and 2'b01 when it is 0.
- R7: A byte read makes one transfer. It returns mem_rdata[15:8] when address bit 0 is 1 and mem_rdata[7:0] when it is 0, zero-extended to 32 bits.
- R8: A non-display request to a segment whose cacheable bit is set goes to the cache port with no external transfer, and core_rdata returns cache_rdata.
- R9: A display request (core_disp = 1) never uses the cache port, even when its segment is cacheable, and follows R2 to R7 on the external bus.
- R10: mem_req stays high with stable mem_addr and mem_wdata until mem_ack. core_ready is a single-cycle pulse.
- R11: The segment index is the top log2(NUM_SEG) address bits, and it selects bit [index] of seg_hw_mode and of seg_cacheable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_hw_mode | input | NUM_SEG | Half-word mode bit per segment |
| seg_cacheable | input | NUM_SEG | Cacheable bit per segment |
| core_req | input | 1 | Core request, held until core_ready |
| core_addr | input | ADDR_W | Byte address |
| core_wdata | input | 32 | Write data |
| core_word | input | 1 | 1 = word, 0 = byte |
| core_write | input | 1 | 1 = write, 0 = read |
| core_disp | input | 1 | Request is a display refresh |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Read data, valid with core_ready |
| mem_req | output | 1 | External transfer request |
| mem_addr | output | ADDR_W | External byte address |
| mem_wdata | output | 16 | External write data |
| mem_byte_en | output | 2 | Lane enables, bit 1 = upper byte |
| mem_write | output | 1 | External transfer is a write |
| mem_ack | input | 1 | External transfer acknowledge |
| mem_rdata | input | 16 | External read data |
| cache_req | output | 1 | Cache port request |
| cache_addr | output | ADDR_W | Cache port address |
| cache_wdata | output | 32 | Cache port write data |
| cache_word | output | 1 | Cache port size flag |
| cache_write | output | 1 | Cache port direction |
| cache_ack | input | 1 | Cache port acknowledge |
| cache_rdata | input | 32 | Cache port read data |

## Verification
The bench goes after the split word read. A design that raised ready after the first half would return a word with a missing upper half, and a design with the halves swapped would get {lo, hi}. Half-word reads are run with both signs of the returned value, so a design that zero-extends, or that still splits the word, shows a wrong upper half or an extra transfer. Byte accesses are run on both lanes, which exposes an inverted lane select or a sign-extended byte. A display request to a cacheable segment catches a design that trusts the cacheable bit alone, because that design would raise cache_req and make no external transfer.

// File: rtl/hwba_pkg.sv
// Package: shared state and control types for the half-word bus adapter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hwba_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CACHE,
        ST_LO,
        ST_HI,
        ST_DONE
    } hwba_state_e;

    typedef struct packed {
        logic word;
        logic write;
        logic hw;
        logic to_cache;
    } hwba_ctl_t;

endpackage

// File: rtl/hwba_route.sv
// Module: hwba_route
// Decodes the segment from the top address bits and returns its half-word
// mode bit and whether the request goes to the cache port.
// Assumes: NUM_SEG is a power of two of at least 2.
module hwba_route #(
    parameter int ADDR_W  = 24,
    parameter int NUM_SEG = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               disp,
    input  logic [NUM_SEG-1:0] seg_hw_mode,
    input  logic [NUM_SEG-1:0] seg_cacheable,
    output logic               hw,
    output logic               to_cache
);
    localparam int SEG_W = $clog2(NUM_SEG);

    logic [SEG_W-1:0] seg_idx;

    // Pick the segment bits and look up both attributes; display refresh bypasses the cache.
    always_comb begin
        seg_idx  = addr[ADDR_W-1 -: SEG_W];
        hw       = seg_hw_mode[seg_idx];
        to_cache = seg_cacheable[seg_idx] & ~disp;
    end
endmodule

// File: rtl/hwba_lane.sv
// Module: hwba_lane
// Forms the external address, write data and lane enables for the current
// transfer phase from the latched request.
// Assumes: word accesses are word aligned; bits [1:0] are ignored for them.
module hwba_lane #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [31:0]       wdata_q,
    input  logic              word,
    input  logic              hi_phase,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_byte_en
);
    // Build the address, data lanes and enables for one 16-bit transfer.
    always_comb begin
        if (word) begin
            mem_addr    = {addr_q[ADDR_W-1:2], hi_phase, 1'b0};
            mem_wdata   = hi_phase ? wdata_q[31:16] : wdata_q[15:0];
            mem_byte_en = 2'b11;
        end else begin
            mem_addr    = addr_q;
            mem_wdata   = {wdata_q[7:0], wdata_q[7:0]};
            mem_byte_en = addr_q[0] ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/hwba_rdata.sv
// Module: hwba_rdata
// Assembles the 32-bit read value from the external half-word(s):
// zero-extended byte, sign-extended half-word, or joined split word.
// Assumes: lo_hold carries the first half of a split word.
module hwba_rdata (
    input  logic [15:0] lo_hold,
    input  logic [15:0] mem_rdata,
    input  logic        word,
    input  logic        hw,
    input  logic        byte_hi,
    output logic [31:0] value
);
    // Select the extension rule that matches the access size and mode.
    always_comb begin
        if (!word) begin
            value = {24'b0, (byte_hi ? mem_rdata[15:8] : mem_rdata[7:0])};
        end else if (hw) begin
            value = {{16{mem_rdata[15]}}, mem_rdata};
        end else begin
            value = {mem_rdata, lo_hold};
        end
    end
endmodule

// File: rtl/hw_bus_adapter.sv
// Module: hw_bus_adapter
// Adapts core word/byte requests to a 16-bit external bus under a per-segment
// half-word mode bit, or forwards them to a cache port under a per-segment
// cacheable bit. Display refresh requests always use the external bus.
// Assumes: the core holds its request and fields stable until core_ready, and
// drops or replaces the request in the cycle after core_ready.
module hw_bus_adapter #(
    parameter int ADDR_W  = 24,
    parameter int NUM_SEG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEG-1:0] seg_hw_mode,
    input  logic [NUM_SEG-1:0] seg_cacheable,
    input  logic               core_req,
    input  logic [ADDR_W-1:0]  core_addr,
    input  logic [31:0]        core_wdata,
    input  logic               core_word,
    input  logic               core_write,
    input  logic               core_disp,
    output logic               core_ready,
    output logic [31:0]        core_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [15:0]        mem_wdata,
    output logic [1:0]         mem_byte_en,
    output logic               mem_write,
    input  logic               mem_ack,
    input  logic [15:0]        mem_rdata,
    output logic               cache_req,
    output logic [ADDR_W-1:0]  cache_addr,
    output logic [31:0]        cache_wdata,
    output logic               cache_word,
    output logic               cache_write,
    input  logic               cache_ack,
    input  logic [31:0]        cache_rdata
);
    import hwba_pkg::*;

    hwba_state_e       state;
    hwba_ctl_t         ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic              disp_q;
    logic [15:0]       lo_hold;
    logic [31:0]       rdata_q;
    logic              rt_hw;
    logic              rt_cache;
    logic [31:0]       asm_value;

    hwba_route #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) route_i (
        .addr          (core_addr),
        .disp          (core_disp),
        .seg_hw_mode   (seg_hw_mode),
        .seg_cacheable (seg_cacheable),
        .hw            (rt_hw),
        .to_cache      (rt_cache)
    );

    hwba_lane #(.ADDR_W(ADDR_W)) lane_i (
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .word        (ctl_q.word),
        .hi_phase    (state == ST_HI),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_byte_en (mem_byte_en)
    );

    hwba_rdata rdata_i (
        .lo_hold   (lo_hold),
        .mem_rdata (mem_rdata),
        .word      (ctl_q.word),
        .hw        (ctl_q.hw),
        .byte_hi   (addr_q[0]),
        .value     (asm_value)
    );

    // Sequence a request through cache or one/two external transfers, then pulse ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            disp_q  <= 1'b0;
            lo_hold <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (core_req) begin
                        addr_q         <= core_addr;
                        wdata_q        <= core_wdata;
                        disp_q         <= core_disp;
                        ctl_q.word     <= core_word;
                        ctl_q.write    <= core_write;
                        ctl_q.hw       <= rt_hw;
                        ctl_q.to_cache <= rt_cache;
                        state          <= rt_cache ? ST_CACHE : ST_LO;
                    end
                end
                ST_CACHE: begin
                    if (cache_ack) begin
                        rdata_q <= cache_rdata;
                        state   <= ST_DONE;
                    end
                end
                ST_LO: begin
                    if (mem_ack) begin
                        if (ctl_q.word && !ctl_q.hw) begin
                            lo_hold <= mem_rdata;
                            state   <= ST_HI;
                        end else begin
                            rdata_q <= asm_value;
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_HI: begin
                    if (mem_ack) begin
                        rdata_q <= asm_value;
                        state   <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the port outputs from the current state and latched request.
    always_comb begin
        core_ready  = (state == ST_DONE);
        core_rdata  = rdata_q;
        mem_req     = (state == ST_LO) || (state == ST_HI);
        mem_write   = ctl_q.write;
        cache_req   = (state == ST_CACHE);
        cache_addr  = addr_q;
        cache_wdata = wdata_q;
        cache_word  = ctl_q.word;
        cache_write = ctl_q.write;
    end

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && mem_ack) && mem_req) |-> (mem_addr == $past(mem_addr) + ADDR_W'(2)));

    // R9
    disp_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req |-> !disp_q);

    // R8
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cache_req && mem_req));

    // R4
    hw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && ctl_q.word && ctl_q.hw) |=> core_ready);
endmodule

// File: tb/hw_bus_adapter_tb_top.sv
// Bench: directed scenarios, one task each, checking ports against its own model.
module hw_bus_adapter_tb_top;
    localparam int ADDR_W  = 24;
    localparam int NUM_SEG = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SEG-1:0] seg_hw_mode   = 8'b0000_1100;
    logic [NUM_SEG-1:0] seg_cacheable = 8'b1000_1010;
    logic               core_req = 1'b0;
    logic [ADDR_W-1:0]  core_addr = '0;
    logic [31:0]        core_wdata = '0;
    logic               core_word = 1'b0;
    logic               core_write = 1'b0;
    logic               core_disp = 1'b0;
    logic               core_ready;
    logic [31:0]        core_rdata;
    logic               mem_req;
    logic [ADDR_W-1:0]  mem_addr;
    logic [15:0]        mem_wdata;
    logic [1:0]         mem_byte_en;
    logic               mem_write;
    logic               mem_ack = 1'b0;
    logic [15:0]        mem_rdata;
    logic               cache_req;
    logic [ADDR_W-1:0]  cache_addr;
    logic [31:0]        cache_wdata;
    logic               cache_word;
    logic               cache_write;
    logic               cache_ack = 1'b0;
    logic [31:0]        cache_rdata;

    int checks = 0;
    int fails  = 0;

    // transfer log kept by the responder
    int                xfer_total  = 0;
    int                cache_total = 0;
    logic [ADDR_W-1:0] xa  [0:63];
    logic [15:0]       xw  [0:63];
    logic [1:0]        xbe [0:63];
    logic              xwr [0:63];

    always #10 clk = ~clk;

    hw_bus_adapter #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_hw_mode(seg_hw_mode), .seg_cacheable(seg_cacheable),
        .core_req(core_req), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_word(core_word), .core_write(core_write), .core_disp(core_disp),
        .core_ready(core_ready), .core_rdata(core_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_byte_en(mem_byte_en), .mem_write(mem_write),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cache_req(cache_req), .cache_addr(cache_addr), .cache_wdata(cache_wdata),
        .cache_word(cache_word), .cache_write(cache_write),
        .cache_ack(cache_ack), .cache_rdata(cache_rdata)
    );

    function automatic logic [15:0] mem_model(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ 16'hC35A;
    endfunction

    assign mem_rdata   = mem_model(mem_addr);
    assign cache_rdata = 32'hCAFE0000 | {16'h0, cache_addr[15:0]};

    // external responder: one-cycle ack a cycle after request, logs each transfer
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            mem_ack <= 1'b1;
        end
        if (rst_n && mem_req && mem_ack) begin
            xa[xfer_total[5:0]]  <= mem_addr;
            xw[xfer_total[5:0]]  <= mem_wdata;
            xbe[xfer_total[5:0]] <= mem_byte_en;
            xwr[xfer_total[5:0]] <= mem_write;
            xfer_total           <= xfer_total + 1;
        end
    end

    // cache responder: one-cycle ack a cycle after request
    always @(posedge clk) begin
        if (!rst_n) begin
            cache_ack <= 1'b0;
        end else if (cache_ack) begin
            cache_ack <= 1'b0;
        end else if (cache_req) begin
            cache_ack <= 1'b1;
        end
        if (rst_n && cache_req && cache_ack) cache_total <= cache_total + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic wd, input logic wr,
                          input logic dp, input logic [31:0] d,
                          output logic [31:0] rd, output int nx, output int nc);
        int x0 = xfer_total;
        int c0 = cache_total;
        @(negedge clk);
        core_addr = a; core_word = wd; core_write = wr; core_disp = dp;
        core_wdata = d; core_req = 1'b1;
        do @(negedge clk); while (!core_ready);
        rd = core_rdata;
        nx = xfer_total - x0;
        nc = cache_total - c0;
        core_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(core_ready), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 cache_req", 32'(cache_req), 32'd0);
    endtask

    task automatic t_split_read();
        logic [31:0] rd; int nx; int nc; int b;
        b = xfer_total;
        access(24'h000102, 1'b1, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R2 xfer count at ready", 32'(nx), 32'd2);
        chk("R2 first addr", 32'(xa[b[5:0]]), 32'h000100);
        chk("R2 second addr", 32'(xa[6'(b+1)]), 32'h000102);
        chk("R2 data", rd, {mem_model(24'h000102), mem_model(24'h000100)});
    endtask

    task automatic t_split_write();
        logic [31:0] rd; int nx; int nc; int b;
        b = xfer_total;
        access(24'h000200, 1'b1, 1'b1, 1'b0, 32'h12345678, rd, nx, nc);
        chk("R3 xfer count", 32'(nx), 32'd2);
        chk("R3 low data", 32'(xw[b[5:0]]), 32'h5678);
        chk("R3 high data", 32'(xw[6'(b+1)]), 32'h1234);
        chk("R3 enables", {xbe[b[5:0]], xbe[6'(b+1)]}, 32'hF);
        chk("R3 write flag", 32'(xwr[b[5:0]] & xwr[6'(b+1)]), 32'd1);
    endtask

    task automatic t_hw_read();
        logic [31:0] rd; int nx; int nc; int b;
        b = xfer_total;
        access(24'h400012, 1'b1, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R4 single xfer", 32'(nx), 32'd1);
        chk("R4 aligned addr", 32'(xa[b[5:0]]), 32'h400010);
        chk("R4 negative sign-extend", rd, 32'hFFFFC34A);
        access(24'h408010, 1'b1, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R4 positive sign-extend", rd, 32'h0000434A);
    endtask

    task automatic t_hw_write();
        logic [31:0] rd; int nx; int nc; int b;
        b = xfer_total;
        access(24'h400020, 1'b1, 1'b1, 1'b0, 32'hDEADBEEF, rd, nx, nc);
        chk("R5 single xfer", 32'(nx), 32'd1);
        chk("R5 low data only", 32'(xw[b[5:0]]), 32'hBEEF);
        chk("R5 enables", 32'(xbe[b[5:0]]), 32'h3);
    endtask

    task automatic t_byte_write();
        logic [31:0] rd; int nx; int nc; int b;
        b = xfer_total;
        access(24'h000031, 1'b0, 1'b1, 1'b0, 32'h000000A7, rd, nx, nc);
        chk("R6 single xfer", 32'(nx), 32'd1);
        chk("R6 addr odd", 32'(xa[b[5:0]]), 32'h000031);
        chk("R6 lane odd", 32'(xbe[b[5:0]]), 32'h2);
        chk("R6 data both lanes", 32'(xw[b[5:0]]), 32'hA7A7);
        b = xfer_total;
        access(24'h400030, 1'b0, 1'b1, 1'b0, 32'h0000005C, rd, nx, nc);
        chk("R6 hw-mode single xfer", 32'(nx), 32'd1);
        chk("R6 lane even", 32'(xbe[b[5:0]]), 32'h1);
    endtask

    task automatic t_byte_read();
        logic [31:0] rd; int nx; int nc;
        access(24'h400041, 1'b0, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R7 upper lane zero-ext", rd, 32'h000000C3);
        access(24'h000040, 1'b0, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R7 lower lane", rd, 32'h0000001A);
    endtask

    task automatic t_cache();
        logic [31:0] rd; int nx; int nc;
        access(24'h200050, 1'b1, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R8 cache used", 32'(nc), 32'd1);
        chk("R8 no ext xfer", 32'(nx), 32'd0);
        chk("R8 cache data", rd, 32'hCAFE0050);
        // R11: segment 7 cacheable, segment 6 not
        access(24'hE00060, 1'b0, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R11 seg7 cacheable", 32'(nc), 32'd1);
        access(24'hC00060, 1'b0, 1'b0, 1'b0, 32'h0, rd, nx, nc);
        chk("R11 seg6 external", 32'(nx), 32'd1);
    endtask

    task automatic t_display();
        logic [31:0] rd; int nx; int nc;
        access(24'h200070, 1'b1, 1'b0, 1'b1, 32'h0, rd, nx, nc);
        chk("R9 no cache", 32'(nc), 32'd0);
        chk("R9 split on bus", 32'(nx), 32'd2);
        chk("R9 data", rd, {mem_model(24'h000072), mem_model(24'h000070)});
        access(24'h600080, 1'b1, 1'b0, 1'b1, 32'h0, rd, nx, nc);
        chk("R9 hw-mode cacheable seg single xfer", 32'(nx), 32'd1);
        chk("R9 hw-mode no cache", 32'(nc), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_split_read();
        t_split_write();
        t_hw_read();
        t_hw_write();
        t_byte_write();
        t_byte_read();
        t_cache();
        t_display();
        // R10: ready already checked as a pulse by the design; confirm idle after access
        chk("R10 ready low after access", 32'(core_ready), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule